// File: doc/BRIEF.md
# I2C Bus Clear Sequencer

This block frees an I2C bus that a slave is holding stuck with SDA low. Once it is started, it toggles SCL for up to a programmed number of clock pulses and watches SDA during each high phase. It can stop as soon as the slave lets SDA go, and it can finish with a STOP condition so that every device on the bus sees the bus return to idle. A free-running `tick_i` strobe sets the timing of the bus. Each SCL phase and each STOP phase ends on a tick.

Software writes the pulse count and the option bits into a staging copy of the configuration. It then issues a load command, which copies the staged values into the active copy that the engine uses. Setting the enable bit starts a run, and that bit reads 1 until the run ends. At the end of a run the block records whether SDA was found released and raises a done interrupt. The interrupt stays set until software clears it.

Register map (word index on `addr_i`):
- 0, configuration: pulse threshold in bits 23:16, trailing STOP enable in bit 2, early terminate enable in bit 1, enable/run in bit 0.
- 1, load command: bit 0.
- 2, result: bit 0.
- 3, interrupt status: done flag in bit 11.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, all four registers read 0, `scl_low_o` and `sda_low_o` are 0 (lines released) and `irq_o` is 0.
- R2: Writing 1 to bit 0 of register 1 copies the staged threshold and option bits into the active copy. The bit reads 1 until the copy is made and 0 after that. A load issued while a run is in progress is held pending until the engine is idle.
- R3: Register 0 reads back the staged threshold in bits 23:16 and the staged STOP and terminate bits in bits 2 and 1. A run always uses the active copy, so staged values that have not been loaded have no effect on the pulse count.
- R4: Writing register 0 with bit 0 set while idle starts a run. Bit 0 reads 1 while the run is in progress and returns to 0 by itself when the run ends. Writing the enable bit during a run does not restart or extend the run.
- R5: Each pulse drives SCL low (`scl_low_o`=1) until a tick and then releases it until the next tick. With SDA held low, exactly the threshold number of pulses are issued.
- R6: When the terminate bit is set, SDA is sampled at the tick that ends each high phase. The pulse train stops after the first pulse whose sample is 1.
- R7: When the terminate bit is clear, a released SDA does not shorten the run, and the full threshold number of pulses is issued.
- R8: When the STOP bit is set, the pulses are followed by three phases of one tick each: SCL and SDA both driven low, then SCL released with SDA still low, then both released. `sda_low_o` is never 1 outside this STOP sequence.
- R9: At the end of a run, register 2 bit 0 holds the last SDA sample: 1 means the bus was freed, 0 means it is still held.
- R10: Completion sets bit 11 of register 3. `irq_o` follows that bit. Writing 1 to bit 11 clears it.
- R11: A threshold of 0 issues no pulses and completes at once, with the result taken from SDA at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Strobe that ends each bus phase |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register word index for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| sda_i | input | 1 | Sampled SDA line level |
| scl_low_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 drives SDA low, 0 releases it |
| irq_o | output | 1 | Done interrupt |

## Verification
The assertions check on every cycle that:
- the active settings do not change while a run is in progress;
- a pending load completes on the first idle cycle;
- the pulse counter never passes the threshold;
- SDA is driven only when the STOP option is active;
- a start is never accepted during a run;
- the interrupt follows completion one cycle later.

Only the directed scenarios can show the following, because each depends on a slave model that lets SDA go after a chosen pulse:
- the exact number of pulses issued;
- the point where early termination stops the train;
- the length of each STOP phase;
- the result bit;
- that a staged but unloaded threshold has no effect.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;
  localparam int BC_AW = 2;
  localparam int BC_DW = 32;

  localparam logic [BC_AW-1:0] ADDR_CFG  = 2'd0;
  localparam logic [BC_AW-1:0] ADDR_LOAD = 2'd1;
  localparam logic [BC_AW-1:0] ADDR_STAT = 2'd2;
  localparam logic [BC_AW-1:0] ADDR_INT  = 2'd3;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_TERM_BIT = 1;
  localparam int CFG_STOP_BIT = 2;
  localparam int CFG_THR_LSB  = 16;
  localparam int LOAD_BIT     = 0;
  localparam int INT_DONE_BIT = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SP1,
    ST_SP2,
    ST_SP3,
    ST_FIN
  } bc_state_e;
endpackage

// File: rtl/i2c_bc_regs.sv
module i2c_bc_regs
  import i2c_bc_pkg::*;
#(
  parameter int THR_W = 8,
  parameter int DW    = BC_DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BC_AW-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             freed_i,
  output logic             start_o,
  output logic [THR_W-1:0] act_thr_o,
  output logic             act_term_o,
  output logic             act_stop_o,
  output logic             irq_o
);
  logic [THR_W-1:0] stg_thr_q;
  logic             stg_term_q;
  logic             stg_stop_q;
  logic             load_pend_q;
  logic             stat_q;
  logic             intr_q;
  logic             unused_wdata;

  logic wr_cfg, wr_load, wr_int;
  assign wr_cfg  = wr_en_i && (addr_i == ADDR_CFG);
  assign wr_load = wr_en_i && (addr_i == ADDR_LOAD) && wdata_i[LOAD_BIT];
  assign wr_int  = wr_en_i && (addr_i == ADDR_INT) && wdata_i[INT_DONE_BIT];
  assign unused_wdata = ^wdata_i;

  assign start_o = wr_cfg && wdata_i[CFG_EN_BIT] && !busy_i;
  assign irq_o   = intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_thr_q   <= '0;
      stg_term_q  <= 1'b0;
      stg_stop_q  <= 1'b0;
      act_thr_o   <= '0;
      act_term_o  <= 1'b0;
      act_stop_o  <= 1'b0;
      load_pend_q <= 1'b0;
      stat_q      <= 1'b0;
      intr_q      <= 1'b0;
    end else begin
      if (wr_cfg) begin
        stg_thr_q  <= wdata_i[CFG_THR_LSB +: THR_W];
        stg_term_q <= wdata_i[CFG_TERM_BIT];
        stg_stop_q <= wdata_i[CFG_STOP_BIT];
      end
      // commit deferred while a run is using the active copy
      if (load_pend_q && !busy_i) begin
        act_thr_o   <= stg_thr_q;
        act_term_o  <= stg_term_q;
        act_stop_o  <= stg_stop_q;
        load_pend_q <= 1'b0;
      end
      if (wr_load) load_pend_q <= 1'b1;
      if (done_i) stat_q <= freed_i;
      if (wr_int) intr_q <= 1'b0;
      if (done_i) intr_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG: begin
        rdata_o[CFG_THR_LSB +: THR_W] = stg_thr_q;
        rdata_o[CFG_STOP_BIT]         = stg_stop_q;
        rdata_o[CFG_TERM_BIT]         = stg_term_q;
        rdata_o[CFG_EN_BIT]           = busy_i;
      end
      ADDR_LOAD: rdata_o[LOAD_BIT]     = load_pend_q;
      ADDR_STAT: rdata_o[0]            = stat_q;
      default:   rdata_o[INT_DONE_BIT] = intr_q;
    endcase
  end

  a_r2_load_commits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_pend_q && !busy_i && !wr_load |=> !load_pend_q);
  a_r3_active_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> $stable(act_thr_o) && $stable(act_term_o) && $stable(act_stop_o));
  a_r10_done_sets_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> irq_o);
  a_r4_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !start_o);
endmodule

// File: rtl/i2c_bc_engine.sv
module i2c_bc_engine
  import i2c_bc_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             term_i,
  input  logic             stop_i,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             freed_o
);
  bc_state_e        state_q;
  logic [THR_W-1:0] cnt_q;
  logic [THR_W-1:0] cnt_nxt;
  logic             samp_q;
  logic             last_pulse;

  assign cnt_nxt    = cnt_q + 1'b1;
  assign last_pulse = (term_i && sda_i) || (cnt_nxt == thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      samp_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cnt_q <= '0;
          if (thr_i == '0) begin
            samp_q  <= sda_i;
            state_q <= ST_FIN;
          end else begin
            state_q <= ST_LOW;
          end
        end
        ST_LOW:  if (tick_i) state_q <= ST_HIGH;
        ST_HIGH: if (tick_i) begin
          samp_q <= sda_i;
          cnt_q  <= cnt_nxt;
          if (last_pulse) state_q <= stop_i ? ST_SP1 : ST_FIN;
          else            state_q <= ST_LOW;
        end
        ST_SP1:  if (tick_i) state_q <= ST_SP2;
        ST_SP2:  if (tick_i) state_q <= ST_SP3;
        ST_SP3:  if (tick_i) state_q <= ST_FIN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_low_o = (state_q == ST_LOW) || (state_q == ST_SP1);
  assign sda_low_o = (state_q == ST_SP1) || (state_q == ST_SP2);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_FIN);
  assign freed_o   = samp_q;

  a_r4_done_ends_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (thr_i != '0) |-> cnt_q <= thr_i);
  a_r8_sda_only_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_low_o |-> stop_i);
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !scl_low_o && !sda_low_o);
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bc_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [BC_AW-1:0] addr_i,
  input  logic [BC_DW-1:0] wdata_i,
  output logic [BC_DW-1:0] rdata_o,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             irq_o
);
  logic             start, busy, done, freed;
  logic [THR_W-1:0] act_thr;
  logic             act_term, act_stop;

  i2c_bc_regs #(.THR_W(THR_W), .DW(BC_DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .freed_i(freed), .start_o(start),
    .act_thr_o(act_thr), .act_term_o(act_term), .act_stop_o(act_stop),
    .irq_o
  );

  i2c_bc_engine #(.THR_W(THR_W)) u_engine (
    .clk_i, .rst_ni, .tick_i, .start_i(start),
    .thr_i(act_thr), .term_i(act_term), .stop_i(act_stop), .sda_i,
    .scl_low_o, .sda_low_o, .busy_o(busy), .done_o(done), .freed_o(freed)
  );
endmodule

// File: tb/i2c_bus_clear_tb_top.sv
module i2c_bus_clear_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_low, sda_low, irq;
  logic [1:0]  tdiv = '0;
  logic        tick;
  int          checks = 0;
  int          errors = 0;
  int          pulses = 0, ph_a = 0, ph_b = 0, stray_sda = 0;
  int          rel_k = 1000;
  logic        clr_mon = 1'b0;
  logic        prev_scl = 1'b0, prev_sda = 1'b0;
  logic        stop_mode = 1'b0;
  logic        sda_line;

  always #4 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);
  // open-drain bus with a slave that lets go after rel_k pulses
  assign sda_line = !sda_low && (pulses >= rel_k);

  i2c_bus_clear dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .irq_o(irq)
  );

  always @(posedge clk) begin
    prev_scl <= scl_low;
    prev_sda <= sda_low;
    if (clr_mon) begin
      pulses <= 0; ph_a <= 0; ph_b <= 0; stray_sda <= 0;
    end else begin
      if (prev_scl && !scl_low && !prev_sda) pulses <= pulses + 1;
      if (scl_low && sda_low) ph_a <= ph_a + 1;
      if (!scl_low && sda_low) ph_b <= ph_b + 1;
      if (sda_low && !stop_mode) stray_sda <= stray_sda + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cfg(int thr, bit stop, bit term, bit en);
    return (32'(thr) << 16) | (32'(stop) << 2) | (32'(term) << 1) | 32'(en);
  endfunction

  task automatic load_cfg(int thr, bit stop, bit term);
    wr(2'd0, cfg(thr, stop, term, 1'b0));
    wr(2'd1, 32'h1);
    @(negedge clk);
    stop_mode = stop;
  endtask

  task automatic wait_done(string req);
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
    chk(req, int'(irq), 1);
  endtask

  task automatic clear_irq();
    wr(2'd3, 32'h800);
  endtask

  task automatic run(int thr, bit stop, bit term, int rel,
                     int exp_p, int exp_st, string req);
    logic [31:0] d;
    load_cfg(thr, stop, term);
    rel_k = rel;
    clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
    wr(2'd0, cfg(thr, stop, term, 1'b1));
    wait_done(req);
    chk({req, " pulses"}, pulses, exp_p);
    rd(2'd2, d); chk({req, " R9 status"}, int'(d[0]), exp_st);
    rd(2'd0, d); chk({req, " R4 enable cleared"}, int'(d[0]), 0);
    if (!stop) chk({req, " R8 no stray SDA"}, stray_sda, 0);
    clear_irq();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); chk("R1 reg reset", int'(d), 0);
    end
    chk("R1 scl released", int'(scl_low), 0);
    chk("R1 sda released", int'(sda_low), 0);
    chk("R1 irq low", int'(irq), 0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(2'd0, cfg(3, 1'b1, 1'b1, 1'b0));
    rd(2'd0, d);
    chk("R3 staged thr readback", int'(d[23:16]), 3);
    chk("R3 staged stop/term readback", int'(d[2:1]), 3);
    @(negedge clk); wr_en = 1'b1; addr = 2'd1; wdata = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    rd(2'd1, d); chk("R2 load pending", int'(d[0]), 1);
    @(negedge clk);
    rd(2'd1, d); chk("R2 load self clears", int'(d[0]), 0);
  endtask

  task automatic t_full_hold();
    run(3, 1'b0, 1'b0, 1000, 3, 0, "R5 full run held");
  endtask

  task automatic t_irq();
    logic [31:0] d;
    load_cfg(1, 1'b0, 1'b0);
    rel_k = 1000;
    wr(2'd0, cfg(1, 1'b0, 1'b0, 1'b1));
    wait_done("R10 irq raised");
    rd(2'd3, d); chk("R10 int bit 11", int'(d[11]), 1);
    clear_irq();
    rd(2'd3, d); chk("R10 int cleared", int'(d), 0);
    chk("R10 irq low after clear", int'(irq), 0);
  endtask

  task automatic t_no_term();
    run(3, 1'b0, 1'b0, 1, 3, 1, "R7 no early stop");
  endtask

  task automatic t_staged();
    logic [31:0] d;
    load_cfg(3, 1'b0, 1'b0);
    rel_k = 1000;
    clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
    wr(2'd0, cfg(6, 1'b0, 1'b0, 1'b1));
    rd(2'd0, d); chk("R4 enable reads 1", int'(d[0]), 1);
    wait_done("R3 run");
    chk("R3 unloaded thr ignored", pulses, 3);
    clear_irq();
  endtask

  task automatic t_term();
    run(10, 1'b0, 1'b1, 2, 2, 1, "R6 early terminate");
  endtask

  task automatic t_stop();
    run(2, 1'b1, 1'b0, 1000, 2, 0, "R8 stop run");
    chk("R8 phase SCL+SDA low ticks", ph_a, 4);
    chk("R8 phase SDA low SCL high ticks", ph_b, 4);
    stop_mode = 1'b0;
  endtask

  task automatic t_thr0();
    run(0, 1'b0, 1'b0, 0, 0, 1, "R11 zero threshold");
  endtask

  task automatic t_busy();
    logic [31:0] d;
    load_cfg(10, 1'b0, 1'b0);
    rel_k = 1000;
    clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
    wr(2'd0, cfg(10, 1'b0, 1'b0, 1'b1));
    repeat (10) @(negedge clk);
    rd(2'd0, d); chk("R4 running", int'(d[0]), 1);
    wr(2'd0, cfg(2, 1'b0, 1'b0, 1'b1));
    wr(2'd1, 32'h1);
    repeat (3) @(negedge clk);
    rd(2'd1, d); chk("R2 load deferred while busy", int'(d[0]), 1);
    wait_done("R4 busy run");
    chk("R4 re-enable ignored", pulses, 10);
    clear_irq();
    repeat (2) @(negedge clk);
    rd(2'd1, d); chk("R2 deferred load done", int'(d[0]), 0);
    clr_mon = 1'b1; @(negedge clk); clr_mon = 1'b0;
    wr(2'd0, cfg(2, 1'b0, 1'b0, 1'b1));
    wait_done("R2 run");
    chk("R2 deferred thr active", pulses, 2);
    clear_irq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_full_hold();
    t_irq();
    t_no_term();
    t_staged();
    t_term();
    t_stop();
    t_thr0();
    t_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule